// File: doc/BRIEF.md
# Debug Breakpoint Request Arbiter

This block sits between the event sources of an on-chip debug unit and the CPU. It decides whether a breakpoint is raised, and where it goes. The event sources are comparator matches, tag hits, a trigger written by software, and the end of a trace session. The possible targets are the background debug mode (BDM) entry, a software-interrupt (SWI) breakpoint, or nothing. A single pending flag records that a breakpoint is owed to the CPU. That flag lives through BDM sessions and through trace windows, and it clears only on an acknowledge or a disarm.

The route is recomputed every cycle from four status inputs: the break enable, the BDM-select bit, BDM enabled and BDM active. A pending request therefore vanishes from the outputs while BDM is running and returns by itself once BDM exits. Two coincidence rules tell the CPU what to do with an SWI or BGND instruction in user code that meets a breakpoint. Their result is reported on `suppressSwi`.

Top module: `brk_arb`

## Requirements
- R1: While `rstN` is low at a clock edge, the pending flag is cleared, so `reqBdm`, `reqSwi` and `suppressSwi` are all 0 after that edge.
- R2: With `brkEn`=0, no request output is asserted, whatever the pending state.
- R3: A pending request appears on `reqBdm` when `brkEn`=1, `bdmSel`=1, `bdmEnabled`=1 and `bdmActive`=0. It appears on `reqSwi` when `brkEn`=1 and either `bdmSel`=0 or `bdmEnabled`=0.
- R4: While `bdmEnabled` and `bdmActive` are both 1, no request is asserted, but the pending flag is kept. The request reappears in the first cycle after `bdmActive` falls.
- R5: While `bdmActive`=1, `cmpHit` and `tagHit` raise no request. While `bdmTraceCmd`=1, `tagHit` raises no request.
- R6: A cycle with `armEn`=1 and `trigWr`=1, outside a trace window, sets a request that is visible in the next cycle. With `armEn`=0, no source sets a request.
- R7: While `traceBusy`=1, `trigWr`, `cmpHit` and `tagHit` are ignored. A `traceDone` pulse while `armEn`=1 sets a request that is visible in the next cycle.
- R8: `ack`=1 clears the pending request after the edge. `armEn`=0 clears it after the edge and takes priority over any new event.
- R9: `reqBdm` and `reqSwi` are never 1 together.
- R10: Suppose an SWI-routed pending request meets `userBgnd`=1 with `bdmEnabled`=1. In that cycle `reqSwi`=0 and `suppressSwi`=1, and the request is discarded at the edge.
- R11: Suppose a BDM-routed pending request meets `userSwi`=1. In that cycle `reqBdm`=1 and `suppressSwi`=1, so the user SWI waits until BDM returns.
- R12: A new event in the same cycle as `ack` leaves the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| armEn | input | 1 | Arm bit from the control register |
| trigWr | input | 1 | Pulse: trigger bit written |
| brkEn | input | 1 | Debug break enable |
| bdmSel | input | 1 | Select BDM rather than SWI as target |
| cmpHit | input | NUM_CMP | Comparator match pulses |
| tagHit | input | 1 | Tagged instruction reached execution |
| traceBusy | input | 1 | Begin-aligned trace session in progress |
| traceDone | input | 1 | Pulse: trace session completed |
| bdmEnabled | input | 1 | BDM firmware enabled |
| bdmActive | input | 1 | CPU is executing BDM firmware |
| bdmTraceCmd | input | 1 | A BDM trace command is executing |
| userSwi | input | 1 | Current user instruction is SWI |
| userBgnd | input | 1 | Current user instruction is BGND |
| ack | input | 1 | CPU accepts the current request |
| reqBdm | output | 1 | Request entry to BDM |
| reqSwi | output | 1 | Request an SWI breakpoint |
| suppressSwi | output | 1 | SWI coincidence resolved in favour of BDM |

## Verification
The only state is the pending flag. A wrong value there shows at the ports in the next cycle, provided the status inputs route the request somewhere. It can stay hidden through a whole BDM session or while `brkEn` is low. For that reason the bench compares all three outputs on every cycle, including cycles straight after `bdmActive` falls. A lost deferred request shows up in the cycle after `traceDone`. A missed discard under R10 shows up in the cycle after the BGND coincidence, when `reqSwi` would otherwise come back.

// File: rtl/brk_arb_pkg.sv
package brk_arb_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_SWI  = 2'd1,
    RT_BDM  = 2'd2
  } route_e;

  typedef struct packed {
    logic setPend;     // qualified breakpoint event this cycle
    logic disarm;      // arm bit low: drop everything
    logic ackSeen;     // CPU took the request
    logic dropSwi;     // SWI-routed break swallowed by user BGND
    logic holdUserSwi; // user SWI deferred behind a BDM break
  } strobe_t;
endpackage

// File: rtl/brk_arb_ctrl.sv
module brk_arb_ctrl
  import brk_arb_pkg::*;
#(
  parameter int NUM_CMP = 3
) (
  input  logic               armEn,
  input  logic               trigWr,
  input  logic               brkEn,
  input  logic               bdmSel,
  input  logic [NUM_CMP-1:0] cmpHit,
  input  logic               tagHit,
  input  logic               traceBusy,
  input  logic               traceDone,
  input  logic               bdmEnabled,
  input  logic               bdmActive,
  input  logic               bdmTraceCmd,
  input  logic               userSwi,
  input  logic               userBgnd,
  input  logic               ack,
  output route_e             route,
  output strobe_t            stb
);
  logic anyCmp;
  logic tagOk;
  logic matchSrc;
  logic liveSrc;
  logic evt;

  assign anyCmp   = |cmpHit;
  assign tagOk    = tagHit & ~bdmTraceCmd;
  // comparator and tag sources are dead while firmware runs
  assign matchSrc = ~bdmActive & (anyCmp | tagOk);
  assign liveSrc  = trigWr | matchSrc;
  // within a trace window only the completion pulse counts
  assign evt      = armEn & (traceDone | (~traceBusy & liveSrc));

  always_comb begin
    if (!brkEn || (bdmEnabled && bdmActive))
      route = RT_NONE;
    else if (bdmSel && bdmEnabled)
      route = RT_BDM;
    else
      route = RT_SWI;
  end

  always_comb begin
    stb.setPend     = evt;
    stb.disarm      = ~armEn;
    stb.ackSeen     = ack;
    stb.dropSwi     = (route == RT_SWI) & userBgnd & bdmEnabled;
    stb.holdUserSwi = (route == RT_BDM) & userSwi;
  end
endmodule

// File: rtl/brk_arb_dp.sv
module brk_arb_dp
  import brk_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  route_e  route,
  input  strobe_t stb,
  output logic    reqBdm,
  output logic    reqSwi,
  output logic    suppressSwi
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rstN)
      pend <= 1'b0;
    else if (stb.disarm)
      pend <= 1'b0;
    else if (stb.setPend)
      pend <= 1'b1;
    else if (stb.ackSeen || stb.dropSwi)
      pend <= 1'b0;
  end

  assign reqBdm      = pend & (route == RT_BDM);
  assign reqSwi      = pend & (route == RT_SWI) & ~stb.dropSwi;
  assign suppressSwi = pend & (stb.dropSwi | stb.holdUserSwi);

  a_r1_reset_clears: assert property (@(posedge clk) !rstN |=> !pend)
    else $error("R1 pending survived reset");

  a_r10_bgnd_swallows: assert property (@(posedge clk) disable iff (!rstN)
    (pend && stb.dropSwi) |-> (!reqSwi && suppressSwi))
    else $error("R10 SWI break not swallowed");

  a_r12_set_beats_ack: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setPend && stb.ackSeen && !stb.disarm) |=> pend)
    else $error("R12 event lost to ack");
endmodule

// File: rtl/brk_arb.sv
module brk_arb
  import brk_arb_pkg::*;
#(
  parameter int NUM_CMP = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armEn,
  input  logic               trigWr,
  input  logic               brkEn,
  input  logic               bdmSel,
  input  logic [NUM_CMP-1:0] cmpHit,
  input  logic               tagHit,
  input  logic               traceBusy,
  input  logic               traceDone,
  input  logic               bdmEnabled,
  input  logic               bdmActive,
  input  logic               bdmTraceCmd,
  input  logic               userSwi,
  input  logic               userBgnd,
  input  logic               ack,
  output logic               reqBdm,
  output logic               reqSwi,
  output logic               suppressSwi
);
  route_e  route;
  strobe_t stb;

  brk_arb_ctrl #(.NUM_CMP(NUM_CMP)) u_ctrl (
    .armEn(armEn), .trigWr(trigWr), .brkEn(brkEn), .bdmSel(bdmSel),
    .cmpHit(cmpHit), .tagHit(tagHit), .traceBusy(traceBusy),
    .traceDone(traceDone), .bdmEnabled(bdmEnabled), .bdmActive(bdmActive),
    .bdmTraceCmd(bdmTraceCmd), .userSwi(userSwi), .userBgnd(userBgnd),
    .ack(ack), .route(route), .stb(stb)
  );

  brk_arb_dp u_dp (
    .clk(clk), .rstN(rstN), .route(route), .stb(stb),
    .reqBdm(reqBdm), .reqSwi(reqSwi), .suppressSwi(suppressSwi)
  );

  a_r9_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(reqBdm && reqSwi))
    else $error("R9 both requests high");

  a_r4_quiet_in_bdm: assert property (@(posedge clk) disable iff (!rstN)
    (bdmEnabled && bdmActive) |-> (!reqBdm && !reqSwi))
    else $error("R4 request while BDM active");

  a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rstN)
    !armEn |=> (!reqBdm && !reqSwi && !suppressSwi))
    else $error("R8 request survived disarm");

  a_r2_break_off: assert property (@(posedge clk) disable iff (!rstN)
    !brkEn |-> (!reqBdm && !reqSwi))
    else $error("R2 request with break disabled");
endmodule

// File: tb/brk_arb_bench.sv
module brk_arb_bench;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rstN, armEn, trigWr, brkEn, bdmSel, tagHit, traceBusy, traceDone;
  logic bdmEnabled, bdmActive, bdmTraceCmd, userSwi, userBgnd, ack;
  logic [NC-1:0] cmpHit;
  logic reqBdm, reqSwi, suppressSwi;

  int testCnt = 0;
  int failCnt = 0;
  bit modelPend = 1'b0;

  always #10 clk = ~clk;

  brk_arb #(.NUM_CMP(NC)) u_brk_arb (
    .clk(clk), .rstN(rstN), .armEn(armEn), .trigWr(trigWr), .brkEn(brkEn),
    .bdmSel(bdmSel), .cmpHit(cmpHit), .tagHit(tagHit), .traceBusy(traceBusy),
    .traceDone(traceDone), .bdmEnabled(bdmEnabled), .bdmActive(bdmActive),
    .bdmTraceCmd(bdmTraceCmd), .userSwi(userSwi), .userBgnd(userBgnd),
    .ack(ack), .reqBdm(reqBdm), .reqSwi(reqSwi), .suppressSwi(suppressSwi)
  );

  // Behavioural reference: one flag, routing from the requirement table.
  task automatic cyc(input string tag);
    bit none, toBdm, drop, expB, expS, expU, ev;
    #2;
    none  = !brkEn || (bdmEnabled && bdmActive);
    toBdm = bdmSel && bdmEnabled;
    drop  = !none && !toBdm && userBgnd && bdmEnabled;
    expB  = modelPend && !none && toBdm;
    expS  = modelPend && !none && !toBdm && !drop;
    expU  = modelPend && !none && (drop || (toBdm && userSwi));
    testCnt++;
    if (reqBdm !== expB || reqSwi !== expS || suppressSwi !== expU) begin
      failCnt++;
      $display("FAIL %s: got bdm=%b swi=%b sup=%b, expected bdm=%b swi=%b sup=%b",
               tag, reqBdm, reqSwi, suppressSwi, expB, expS, expU);
    end
    testCnt++;
    if (reqBdm === 1'b1 && reqSwi === 1'b1) begin
      failCnt++;
      $display("FAIL R9: got both requests high, expected at most one");
    end
    ev = armEn && (traceDone || (!traceBusy &&
         (trigWr || (!bdmActive && ((cmpHit != 0) || (tagHit && !bdmTraceCmd))))));
    @(posedge clk);
    if (!rstN) modelPend = 1'b0;
    else if (!armEn) modelPend = 1'b0;
    else if (ev) modelPend = 1'b1;
    else if (ack || drop) modelPend = 1'b0;
    @(negedge clk);
  endtask

  task automatic quiet();
    trigWr = 0; cmpHit = '0; tagHit = 0; traceDone = 0;
    ack = 0; userSwi = 0; userBgnd = 0;
  endtask

  initial begin
    #4_000_000;
    failCnt++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 0; armEn = 1; brkEn = 1; bdmSel = 1; bdmEnabled = 1; bdmActive = 0;
    bdmTraceCmd = 0; traceBusy = 0; quiet();
    trigWr = 1;
    @(negedge clk);
    cyc("R1"); cyc("R1");
    quiet(); rstN = 1;
    cyc("R1");

    // R6: arm+trigger -> BDM route (R3)
    trigWr = 1; cyc("R6"); trigWr = 0;
    cyc("R3"); cyc("R3");
    bdmSel = 0; cyc("R3");           // SWI route
    bdmSel = 1; bdmEnabled = 0; cyc("R3");
    bdmEnabled = 1;
    brkEn = 0; cyc("R2"); brkEn = 1; cyc("R2");
    ack = 1; cyc("R8"); ack = 0; cyc("R8");

    // R6: disarmed trigger does nothing
    armEn = 0; trigWr = 1; cyc("R6"); trigWr = 0; armEn = 1; cyc("R6");

    // R4: BDM active hides, exit reasserts
    cmpHit = 3'b010; cyc("R4"); cmpHit = '0;
    bdmActive = 1; cyc("R4"); cyc("R4");
    bdmActive = 0; cyc("R4");
    ack = 1; cyc("R8"); ack = 0;

    // R5: matches ignored in BDM, tag ignored in trace cmd
    bdmActive = 1; cmpHit = 3'b100; tagHit = 1; cyc("R5");
    quiet(); bdmActive = 0; cyc("R5");
    bdmTraceCmd = 1; tagHit = 1; cyc("R5"); tagHit = 0; bdmTraceCmd = 0; cyc("R5");
    tagHit = 1; cyc("R5"); tagHit = 0; cyc("R5");
    ack = 1; cyc("R8"); ack = 0;

    // R7: trace window
    traceBusy = 1; trigWr = 1; cyc("R7"); trigWr = 0;
    cmpHit = 3'b001; cyc("R7"); cmpHit = '0; cyc("R7");
    traceDone = 1; cyc("R7"); traceDone = 0; traceBusy = 0; cyc("R7");

    // R12: event with ack keeps pending
    ack = 1; cmpHit = 3'b001; cyc("R12"); quiet(); cyc("R12");

    // R8: disarm beats event
    armEn = 0; trigWr = 1; cyc("R8"); quiet(); armEn = 1; cyc("R8");

    // R11: BDM-routed break meets user SWI
    trigWr = 1; cyc("R11"); trigWr = 0;
    userSwi = 1; cyc("R11"); userSwi = 0; cyc("R11");
    ack = 1; cyc("R8"); ack = 0;

    // R10: SWI-routed break meets user BGND
    bdmSel = 0; trigWr = 1; cyc("R10"); trigWr = 0; cyc("R10");
    userBgnd = 1; cyc("R10"); userBgnd = 0; cyc("R10"); cyc("R10");
    // BGND with BDM disabled does not swallow
    bdmEnabled = 0; trigWr = 1; cyc("R10"); trigWr = 0;
    userBgnd = 1; cyc("R10"); userBgnd = 0; cyc("R10");
    bdmEnabled = 1; bdmSel = 1; ack = 1; cyc("R8"); ack = 0; cyc("R8");

    // mixed sweep across routes
    for (int i = 0; i < 64; i++) begin
      quiet();
      brkEn = i[0]; bdmSel = i[1]; bdmEnabled = i[2]; bdmActive = i[3] & i[2];
      cmpHit = {2'b00, i[4]}; ack = i[5];
      userSwi = i[1] ^ i[4]; userBgnd = i[2] ^ i[5];
      cyc("R3");
    end
    quiet();

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule